// File: doc/BRIEF.md
# Cascaded Level Interrupt Controller

This block gathers 96 level-sensitive interrupt sources into two CPU interrupt outputs. Sources are numbered 0 to 95. A low main cause word carries numbers 0 to 31 and a high main cause word carries numbers 32 to 63. Numbers 64 to 95 come from 32 general-purpose pins. Each pin's pending bit is latched in a sticky pin cause word. The masked pin cause bits are ORed per group of eight pins into four summary bits. These summary bits sit at positions 24 to 27 of the high word, so pin interrupts cascade into the high word.

CPU 0 owns masks for the low word, the high word and the pins. A vector register returns the lowest-numbered source that is both asserted and enabled. When the winner is a pin summary bit, the vector is resolved down to the lowest enabled pending pin, giving 64 plus the pin index. CPU 1 sees only the doorbell source through its own mask. Software reaches all state through a small register port: the read is combinational and the write takes effect on the clock edge.

Top module: `casc_irq_ctrl`

## Requirements
- R1: After synchronous reset, the pin cause, pin mask, CPU0 low mask and CPU1 mask all read 0. The CPU0 high mask reads 0x0F000000, and the vector reads 0x80.
- R2: The register map is: 0 low cause, 1 high cause, 2 pin cause, 3 CPU0 low mask, 4 CPU0 high mask, 5 pin mask, 6 CPU1 mask, 7 vector.
- R3: The low and high cause words show `src_lo` and `src_hi` one clock after they are sampled. In the high cause word, bits 24+k (k = 0..3) are not taken from `src_hi`. Each is the OR of (pin cause AND pin mask) over pins 8k to 8k+7.
- R4: A pin cause bit is set on the clock edge where its pin is 1 and was 0 on the previous edge. It stays set after the pin falls. A write to address 2 clears the bits written as 0 and keeps the bits written as 1. A rising pin sets its bit even when a clearing write lands on the same edge.
- R5: The vector is the lowest number among the eligible sources. Eligible low bits are low cause & 0x3DFFFFFE & CPU0 low mask, numbered 0-31. Eligible high bits are high cause & 0x1F0003F7 & CPU0 high mask, numbered 32+bit. Any eligible low bit beats every high bit.
- R6: When the winning high bit lies in positions 24 to 27, the vector becomes 64 plus the index of the lowest set bit of (pin cause AND pin mask).
- R7: When no source is eligible, the vector reads 0x80: bit 7 is set and the number field [6:0] is 0. Otherwise bit 7 is 0 and [6:0] holds the number.
- R8: Cause bits outside the two selection words never affect the vector or `irq_cpu0`.
- R9: `irq_cpu0` is high exactly while some source is eligible, and stays high for as long as that stays true.
- R10: `irq_cpu1` is high exactly when low cause bit 28 and CPU1 mask bit 28 are both set. The CPU1 mask stores only bit 28, and all its other bits read 0.
- R11: Writes to addresses 0, 1 and 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_lo | input | 32 | Level sources for numbers 0-31 |
| src_hi | input | 32 | Level sources for numbers 32-63 (bits 24-27 unused) |
| pin_in | input | 32 | General-purpose pin inputs, numbers 64-95 |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| irq_cpu0 | output | 1 | CPU 0 level interrupt |
| irq_cpu1 | output | 1 | CPU 1 level interrupt (doorbell only) |

## Verification
The bench builds the block with its default parameters. These are the 0x3DFFFFFE and 0x1F0003F7 selection words, the summary field at high bits 24-27, and the doorbell at bit 28. With these values, the reserved low bits 0, 25, 30 and 31 and the reserved high bit 3 can be driven and shown to stay silent. The defaults also put the cascade between high bit 9 and high bit 28, so the bench checks both sides of the pin summary's priority slot. Pin rises, sticky holds and write-zero clears run alongside random source and register traffic. A behavioural model predicts the outputs of every cycle.

// File: rtl/cic_pkg.sv
package cic_pkg;
    localparam int WORD_W = 32;
    localparam int IDX_W  = $clog2(WORD_W);
    localparam int NUM_W  = 7;

    typedef enum logic [2:0] {
        A_CAUSE_LO  = 3'd0,
        A_CAUSE_HI  = 3'd1,
        A_PIN_CAUSE = 3'd2,
        A_MASK0_LO  = 3'd3,
        A_MASK0_HI  = 3'd4,
        A_PIN_MASK  = 3'd5,
        A_MASK1_LO  = 3'd6,
        A_VECTOR    = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic             none;
        logic [NUM_W-1:0] num;
    } vec_t;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } low_t;

    // lowest set bit of a word
    function automatic low_t lowest_bit(input logic [WORD_W-1:0] v);
        low_t r;
        r = '0;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            if (v[i]) begin
                r.hit = 1'b1;
                r.idx = i[IDX_W-1:0];
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/cic_pin_cause.sv
module cic_pin_cause
    import cic_pkg::*;
#(
    parameter int PIN_GROUPS = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [WORD_W-1:0]     pin_in,
    input  logic                  clr_we,
    input  logic [WORD_W-1:0]     clr_data,
    input  logic [WORD_W-1:0]     pin_mask,
    output logic [WORD_W-1:0]     cause_q,
    output logic [PIN_GROUPS-1:0] summary
);
    localparam int GRP = WORD_W / PIN_GROUPS;

    logic [WORD_W-1:0] prev_q;
    logic [WORD_W-1:0] rise;
    logic [WORD_W-1:0] kept;
    logic [WORD_W-1:0] enabled;

    assign rise    = pin_in & ~prev_q;
    assign kept    = clr_we ? (cause_q & clr_data) : cause_q;
    assign enabled = cause_q & pin_mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q <= '0;
            prev_q  <= pin_in;
        end else begin
            cause_q <= kept | rise;
            prev_q  <= pin_in;
        end
    end

    for (genvar g = 0; g < PIN_GROUPS; g++) begin : g_sum
        assign summary[g] = |enabled[g*GRP +: GRP];
    end

    // R4: a rise always lands in the cause word
    p_rise_sets_r4: assert property (@(posedge clk) disable iff (rst)
        (pin_in[0] && !prev_q[0]) |=> cause_q[0]);
    // R4: without a write, no pending bit is lost
    p_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        !clr_we |=> ((cause_q & $past(cause_q)) == $past(cause_q)));
endmodule

// File: rtl/cic_mask_regs.sv
module cic_mask_regs
    import cic_pkg::*;
#(
    parameter logic [WORD_W-1:0] HI_RESET     = 32'h0F00_0000,
    parameter int                DOORBELL_BIT = 28
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [2:0]        addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] m0_lo,
    output logic [WORD_W-1:0] m0_hi,
    output logic [WORD_W-1:0] pin_mask,
    output logic [WORD_W-1:0] m1_lo
);
    logic m1_db_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            m0_lo    <= '0;
            m0_hi    <= HI_RESET;
            pin_mask <= '0;
            m1_db_q  <= 1'b0;
        end else if (we) begin
            case (reg_addr_e'(addr))
                A_MASK0_LO: m0_lo    <= wdata;
                A_MASK0_HI: m0_hi    <= wdata;
                A_PIN_MASK: pin_mask <= wdata;
                A_MASK1_LO: m1_db_q  <= wdata[DOORBELL_BIT];
                default: ;
            endcase
        end
    end

    always_comb begin
        m1_lo               = '0;
        m1_lo[DOORBELL_BIT] = m1_db_q;
    end
endmodule

// File: rtl/cic_prio.sv
module cic_prio
    import cic_pkg::*;
#(
    parameter logic [WORD_W-1:0] LO_VALID     = 32'h3DFF_FFFE,
    parameter logic [WORD_W-1:0] HI_VALID     = 32'h1F00_03F7,
    parameter int                PIN_SUM_LSB  = 24,
    parameter int                DOORBELL_BIT = 28
) (
    input  logic [WORD_W-1:0] cause_lo,
    input  logic [WORD_W-1:0] cause_hi,
    input  logic [WORD_W-1:0] m0_lo,
    input  logic [WORD_W-1:0] m0_hi,
    input  logic [WORD_W-1:0] pin_cause,
    input  logic [WORD_W-1:0] pin_mask,
    output vec_t              vec,
    output logic              any
);
    low_t lo_w, hi_w, pin_w;

    always_comb begin
        lo_w  = lowest_bit(cause_lo & LO_VALID & m0_lo);
        hi_w  = lowest_bit(cause_hi & HI_VALID & m0_hi);
        pin_w = lowest_bit(pin_cause & pin_mask);
        vec   = '{none: 1'b1, num: '0};
        if (lo_w.hit) begin
            vec = '{none: 1'b0, num: {2'b00, lo_w.idx}};
        end else if (hi_w.hit) begin
            if (int'(hi_w.idx) >= PIN_SUM_LSB && int'(hi_w.idx) < DOORBELL_BIT)
                vec = '{none: 1'b0, num: {2'b10, pin_w.idx}};
            else
                vec = '{none: 1'b0, num: {2'b01, hi_w.idx}};
        end
        any = lo_w.hit | hi_w.hit;
    end
endmodule

// File: rtl/casc_irq_ctrl.sv
module casc_irq_ctrl
    import cic_pkg::*;
#(
    parameter logic [WORD_W-1:0] LO_VALID     = 32'h3DFF_FFFE,
    parameter logic [WORD_W-1:0] HI_VALID     = 32'h1F00_03F7,
    parameter logic [WORD_W-1:0] HI_RESET     = 32'h0F00_0000,
    parameter int                PIN_SUM_LSB  = 24,
    parameter int                PIN_GROUPS   = 4,
    parameter int                DOORBELL_BIT = 28
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] src_lo,
    input  logic [31:0] src_hi,
    input  logic [31:0] pin_in,
    input  logic        reg_we,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq_cpu0,
    output logic        irq_cpu1
);
    localparam logic [WORD_W-1:0] SUM_FIELD =
        ((WORD_W'(1) << PIN_GROUPS) - 1) << PIN_SUM_LSB;

    logic [WORD_W-1:0]     cause_lo_q, src_hi_q, cause_hi;
    logic [WORD_W-1:0]     m0_lo, m0_hi, pin_mask, m1_lo, pin_cause;
    logic [PIN_GROUPS-1:0] summary;
    logic                  pin_clr;
    logic                  any;
    vec_t                  vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_lo_q <= '0;
            src_hi_q   <= '0;
        end else begin
            cause_lo_q <= src_lo;
            src_hi_q   <= src_hi;
        end
    end

    assign cause_hi = (src_hi_q & ~SUM_FIELD) |
                      (WORD_W'(summary) << PIN_SUM_LSB);
    assign pin_clr  = reg_we && (reg_addr_e'(reg_addr) == A_PIN_CAUSE);

    cic_pin_cause #(.PIN_GROUPS(PIN_GROUPS)) u_pin (
        .clk(clk), .rst(rst), .pin_in(pin_in), .clr_we(pin_clr),
        .clr_data(reg_wdata), .pin_mask(pin_mask), .cause_q(pin_cause),
        .summary(summary)
    );

    cic_mask_regs #(.HI_RESET(HI_RESET), .DOORBELL_BIT(DOORBELL_BIT)) u_mask (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .m0_lo(m0_lo), .m0_hi(m0_hi), .pin_mask(pin_mask), .m1_lo(m1_lo)
    );

    cic_prio #(
        .LO_VALID(LO_VALID), .HI_VALID(HI_VALID),
        .PIN_SUM_LSB(PIN_SUM_LSB), .DOORBELL_BIT(DOORBELL_BIT)
    ) u_prio (
        .cause_lo(cause_lo_q), .cause_hi(cause_hi), .m0_lo(m0_lo),
        .m0_hi(m0_hi), .pin_cause(pin_cause), .pin_mask(pin_mask),
        .vec(vec), .any(any)
    );

    always_comb begin
        case (reg_addr_e'(reg_addr))
            A_CAUSE_LO:  reg_rdata = cause_lo_q;
            A_CAUSE_HI:  reg_rdata = cause_hi;
            A_PIN_CAUSE: reg_rdata = pin_cause;
            A_MASK0_LO:  reg_rdata = m0_lo;
            A_MASK0_HI:  reg_rdata = m0_hi;
            A_PIN_MASK:  reg_rdata = pin_mask;
            A_MASK1_LO:  reg_rdata = m1_lo;
            default:     reg_rdata = {{(WORD_W-8){1'b0}}, vec};
        endcase
    end

    assign irq_cpu0 = any;
    assign irq_cpu1 = cause_lo_q[DOORBELL_BIT] & m1_lo[DOORBELL_BIT];

    // R9: output and vector agree on pending state
    p_irq_vs_vec_r9: assert property (@(posedge clk) disable iff (rst)
        irq_cpu0 == !vec.none);
    // R7: empty vector carries a zero number
    p_none_zero_r7: assert property (@(posedge clk) disable iff (rst)
        vec.none |-> (vec.num == '0));
    // R5: numbers stay inside the 96-entry space
    p_vec_range_r5: assert property (@(posedge clk) disable iff (rst)
        !vec.none |-> (vec.num < 7'd96));
    // R6: a pin vector needs an enabled pending pin
    p_cascade_r6: assert property (@(posedge clk) disable iff (rst)
        (!vec.none && vec.num >= 7'd64) |-> ((pin_cause & pin_mask) != '0));
    // R10: CPU1 only ever sees the doorbell
    p_cpu1_db_r10: assert property (@(posedge clk) disable iff (rst)
        irq_cpu1 |-> cause_lo_q[DOORBELL_BIT]);
    // R11: cause words follow the sources regardless of writes
    p_ro_cause_r11: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == 3'd0) |=> (cause_lo_q == $past(src_lo)));
endmodule

// File: tb/sim_casc_irq_ctrl.sv
module sim_casc_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] src_lo = '0, src_hi = '0, pin_in = '0, reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_rdata;
    logic        irq_cpu0, irq_cpu1;

    int checks = 0, failures = 0, cyc = 0;
    bit done = 0;

    always #5 clk = ~clk;

    casc_irq_ctrl u0 (
        .clk(clk), .rst(rst), .src_lo(src_lo), .src_hi(src_hi), .pin_in(pin_in),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_cpu0(irq_cpu0), .irq_cpu1(irq_cpu1)
    );

    // behavioural model state
    logic [31:0] m_lo, m_hi, m_pc, m_pm, m_m0l, m_m0h, m_m1, m_prev;

    always @(posedge clk) begin
        if (rst) begin
            m_lo = 0; m_hi = 0; m_pc = 0; m_pm = 0;
            m_m0l = 0; m_m0h = 32'h0F000000; m_m1 = 0; m_prev = pin_in;
        end else begin
            m_lo = src_lo;
            m_hi = src_hi;
            if (reg_we && reg_addr == 2) m_pc = m_pc & reg_wdata;
            m_pc = m_pc | (pin_in & ~m_prev);
            m_prev = pin_in;
            if (reg_we) begin
                if (reg_addr == 3) m_m0l = reg_wdata;
                if (reg_addr == 4) m_m0h = reg_wdata;
                if (reg_addr == 5) m_pm  = reg_wdata;
                if (reg_addr == 6) m_m1  = reg_wdata & 32'h10000000;
            end
        end
    end

    function automatic logic [31:0] hi_view();
        logic [31:0] v = m_hi & ~32'h0F000000;
        for (int g = 0; g < 4; g++)
            if (((m_pc & m_pm) >> (8 * g)) & 32'hFF) v[24 + g] = 1'b1;
        return v;
    endfunction

    function automatic int model_vec();
        logic [31:0] le = m_lo & 32'h3DFFFFFE & m_m0l;
        logic [31:0] he = hi_view() & 32'h1F0003F7 & m_m0h;
        logic [31:0] pe = m_pc & m_pm;
        for (int i = 0; i < 32; i++) if (le[i]) return i;
        for (int i = 0; i < 32; i++) if (he[i]) begin
            if (i >= 24 && i < 28) begin
                for (int p = 0; p < 32; p++) if (pe[p]) return 64 + p;
            end
            return 32 + i;
        end
        return 32'h80;
    endfunction

    function automatic logic [31:0] model_read(input int a);
        case (a)
            0: return m_lo;
            1: return hi_view();
            2: return m_pc;
            3: return m_m0l;
            4: return m_m0h;
            5: return m_pm;
            6: return m_m1;
            default: return model_vec();
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            check(irq_cpu0 == (model_vec() != 32'h80), "R9 irq_cpu0", 32'(irq_cpu0), 32'(model_vec() != 32'h80));
            check(irq_cpu1 == (m_lo[28] & m_m1[28]), "R10 irq_cpu1", 32'(irq_cpu1), 32'(m_lo[28] & m_m1[28]));
            check(reg_rdata == model_read(int'(reg_addr)), "R5 rdata", reg_rdata, model_read(int'(reg_addr)));
        end
    end

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        reg_we = 1; reg_addr = 3'(a); reg_wdata = d;
        step();
        reg_we = 0;
    endtask

    task automatic rd(input int a, input logic [31:0] exp, input string tag);
        reg_addr = 3'(a);
        @(negedge clk);
        check(reg_rdata == exp, tag, reg_rdata, exp);
        step();
    endtask

    task automatic lvl(input logic exp0, input logic exp1, input string tag);
        @(negedge clk);
        check(irq_cpu0 == exp0, {tag, " irq0"}, 32'(irq_cpu0), 32'(exp0));
        check(irq_cpu1 == exp1, {tag, " irq1"}, 32'(irq_cpu1), 32'(exp1));
        step();
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst = 0;
        step();
        // R1 reset values
        rd(0, 0, "R1 cause_lo"); rd(1, 0, "R1 cause_hi"); rd(2, 0, "R1 pin_cause");
        rd(3, 0, "R1 mask0_lo"); rd(4, 32'h0F000000, "R1 mask0_hi");
        rd(5, 0, "R1 pin_mask"); rd(6, 0, "R1 mask1"); rd(7, 32'h80, "R1 vector");
        // R2 map via writes
        wr(3, 32'hFFFFFFFF); wr(4, 32'hFFFFFFFF);
        rd(3, 32'hFFFFFFFF, "R2 mask0_lo addr3");
        // R5 low priority
        src_lo = 32'h9; step();
        rd(7, 3, "R5 low bit3");
        // R8 reserved bits
        src_lo = 32'h42000001; step();
        rd(7, 32'h80, "R8 reserved low"); lvl(0, 0, "R8");
        rd(0, 32'h42000001, "R3 cause_lo");
        src_lo = 32'h400; src_hi = 32'h20; step();
        rd(7, 10, "R5 low beats high");
        src_lo = 0; step();
        rd(7, 37, "R5 high bit5"); rd(1, 32'h20, "R3 cause_hi");
        src_hi = 32'h8; step();
        rd(7, 32'h80, "R8 reserved high");
        src_hi = 32'h0F000000; step();
        rd(1, 0, "R3 summary not from src"); rd(7, 32'h80, "R7 empty vector");
        // pins
        src_hi = 0; wr(5, 32'h40001000);
        pin_in = 32'h40001000; step();
        rd(2, 32'h40001000, "R4 pin rise"); rd(1, 32'h0A000000, "R3 summary");
        rd(7, 76, "R6 cascade");
        src_hi = 32'h200; step();
        rd(7, 41, "R6 hi9 beats pins");
        src_hi = 32'h10000000; step();
        rd(7, 76, "R6 pins beat hi28");
        src_hi = 0; pin_in = 0; step();
        rd(2, 32'h40001000, "R4 sticky");
        wr(2, 32'hFFFFEFFF);
        rd(2, 32'h40000000, "R4 write0 clears"); rd(7, 94, "R6 pin30");
        wr(2, 32'hFFFFFFFF);
        rd(2, 32'h40000000, "R4 write1 keeps");
        pin_in = 32'h1; reg_we = 1; reg_addr = 2; reg_wdata = 0; step(); reg_we = 0;
        rd(2, 32'h1, "R4 rise beats clear");
        wr(2, 0); pin_in = 0;
        rd(7, 32'h80, "R7 none after clear");
        // R9 level hold
        src_lo = 32'h10; step();
        lvl(1, 0, "R9 hold1"); lvl(1, 0, "R9 hold2"); lvl(1, 0, "R9 hold3");
        wr(3, 0);
        lvl(0, 0, "R9 masked");
        // R10 doorbell
        src_lo = 32'h10000000; step();
        lvl(0, 0, "R10 mask1 off");
        wr(6, 32'hFFFFFFFF);
        rd(6, 32'h10000000, "R10 mask1 bits");
        lvl(0, 1, "R10 doorbell");
        src_lo = 32'h20; step();
        lvl(0, 0, "R10 other source");
        // R11 read-only writes
        wr(0, 32'hFFFFFFFF); rd(0, 32'h20, "R11 cause_lo write");
        wr(1, 32'hFFFFFFFF); rd(1, 0, "R11 cause_hi write");
        wr(7, 32'h00000005); rd(7, 32'h80, "R11 vector write");
        // random traffic, compared each cycle by the model
        for (int n = 0; n < 3000; n++) begin
            src_lo = $urandom & $urandom;
            src_hi = $urandom & $urandom;
            if (($urandom % 4) == 0) pin_in = pin_in ^ (32'h1 << ($urandom % 32));
            reg_addr = 3'($urandom % 8);
            reg_we = (($urandom % 3) == 0);
            reg_wdata = (($urandom % 2) == 0) ? $urandom : ~(32'h1 << ($urandom % 32));
            step();
        end
        reg_we = 0;
        step();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule